// File: doc/BRIEF.md
# Sprint Energy Budget Monitor

This block guards a short burst of many-core operation against overrunning the heat the package can store. From the moment a sprint is accepted it adds up the dynamic energy that each core reports once per sample window, with a sleeping core charged at one tenth of its reported figure. At every sample point it also takes away a fixed leak term, which stands for the heat the package sheds at sustainable power. The running total cannot fall below zero or rise past its full-scale value.

The total is compared against two limits. The first limit is the budget less a programmable margin. Crossing it raises a level interrupt, so that software can move all threads onto one core and power the rest down. The second limit is the full budget. Reaching it throttles the clock of the active cores by a ratio equal to the active-core count, and never less than 1. When software acknowledges that migration is finished, the sprint ends and the clock returns to nominal. A new sprint is turned away while the total is still above the warning limit, so the package has to cool first.

Top module: `sprint_budget_mon`

## Requirements
- R1: After reset, irq_o is 0, clk_div_o is 1, sprint_active_o is 0 and the energy total is 0.
- R2: At each sample point during a sprint, the total grows by the sum over cores of core_energy_i (core i at bits [i*E_W +: E_W]). A core whose core_active_i bit is 0 contributes floor(energy/10). The leak_i term is then subtracted.
- R3: If the leak exceeds the previous total plus the added energy, the total becomes 0 rather than wrapping.
- R4: The total saturates at 2**ACC_W-1 rather than wrapping.
- R5: Sample points occur every SAMPLE_PERIOD cycles. They are counted from the cycle in which a sprint is accepted, so the first one falls SAMPLE_PERIOD clock edges after the accepting edge. Between sample points the total holds. Outside a sprint only the leak is applied.
- R6: When, during a sprint, the total first reaches the warning limit (budget_i minus margin_i, floored at 0), irq_o rises one cycle later. It then stays high until irq_clr_i.
- R7: irq_clr_i drops irq_o. irq_o is not raised again while the total stays at or above the warning limit in the same sprint.
- R8: Once the total reaches budget_i during a sprint, clk_div_o follows the number of set core_active_i bits from the next cycle on, with a minimum of 1.
- R9: sw_ack_i during a sprint ends it on the next edge. sprint_active_o then falls and clk_div_o returns to 1.
- R10: sprint_start_i is refused (sprint_active_o stays 0) while the total exceeds the warning limit. It is accepted when the total is at or below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sprint_start_i | input | 1 | Request to begin a sprint (pulse) |
| core_energy_i | input | NUM_CORES*E_W | Per-core dynamic energy of the last window |
| core_active_i | input | NUM_CORES | Per-core activity flags |
| budget_i | input | ACC_W | Energy budget of a sprint |
| margin_i | input | ACC_W | Distance of the warning limit below the budget |
| leak_i | input | ACC_W | Energy shed per sample window |
| sw_ack_i | input | 1 | Software reports migration and power-down done |
| irq_clr_i | input | 1 | Clears the interrupt |
| irq_o | output | 1 | Near-exhaustion interrupt (level) |
| clk_div_o | output | $clog2(NUM_CORES+1) | Clock divide ratio for active cores |
| sprint_active_o | output | 1 | A sprint is in progress |

## Verification
The energy total is not visible at the ports. The hardest thing to observe is therefore its exact value after a sample point, including the sleeping-core tenth, the clamp at zero and the saturation. The bench probes the total by placing the budget exactly on the predicted value in one run and one above it in a second run, then looking for the throttle. Saturation is reached with a reduced accumulator width and all cores at full-scale energy. Under those conditions a wrapped total would fall below the budget.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // a sleeping core is charged at 1/IDLE_SHARE_DIV of its reported energy
  localparam int unsigned IDLE_SHARE_DIV = 10;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SPRINT = 1'b1
  } sprint_st_e;
endpackage

// File: rtl/sbm_sample_timer.sv
module sbm_sample_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R5
endmodule

// File: rtl/sbm_energy_sum.sv
module sbm_energy_sum
  import sbm_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned E_W       = 10,
  parameter int unsigned SUM_W     = E_W + $clog2(NUM_CORES + 1),
  parameter int unsigned DIV_W     = $clog2(NUM_CORES + 1)
) (
  input  logic [NUM_CORES*E_W-1:0] energy_i,
  input  logic [NUM_CORES-1:0]     active_i,
  output logic [SUM_W-1:0]         sum_o,
  output logic [DIV_W-1:0]         count_o
);
  logic [E_W-1:0] weighted [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [E_W-1:0] raw;
    assign raw         = energy_i[i*E_W +: E_W];
    assign weighted[i] = active_i[i] ? raw : E_W'(raw / E_W'(IDLE_SHARE_DIV));
  end

  always_comb begin
    sum_o   = '0;
    count_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      sum_o   = sum_o + SUM_W'(weighted[i]);
      count_o = count_o + DIV_W'(active_i[i]);
    end
  end
endmodule

// File: rtl/sbm_accum.sv
module sbm_accum #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned SUM_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             add_en_i,
  input  logic [SUM_W-1:0] add_i,
  input  logic [ACC_W-1:0] leak_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int unsigned XW = ((ACC_W > SUM_W) ? ACC_W : SUM_W) + 1;
  localparam logic [XW-1:0] ACC_MAX = XW'({ACC_W{1'b1}});

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [XW-1:0]    gross, net;

  always_comb begin
    gross = XW'(acc_q) + (add_en_i ? XW'(add_i) : '0);
    net   = gross - XW'(leak_i);
    if (gross <= XW'(leak_i)) acc_d = '0;          // clamp at zero
    else if (net > ACC_MAX)   acc_d = {ACC_W{1'b1}}; // saturate
    else                      acc_d = net[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q)); // R5
  AST_LEAK_ONLY_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !add_en_i) |=> acc_q <= $past(acc_q)); // R5
endmodule

// File: rtl/sprint_budget_mon.sv
module sprint_budget_mon
  import sbm_pkg::*;
#(
  parameter int unsigned NUM_CORES     = 4,
  parameter int unsigned E_W           = 10,
  parameter int unsigned ACC_W         = 24,
  parameter int unsigned SAMPLE_PERIOD = 1000,
  localparam int unsigned DIV_W        = $clog2(NUM_CORES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sprint_start_i,
  input  logic [NUM_CORES*E_W-1:0] core_energy_i,
  input  logic [NUM_CORES-1:0]     core_active_i,
  input  logic [ACC_W-1:0]         budget_i,
  input  logic [ACC_W-1:0]         margin_i,
  input  logic [ACC_W-1:0]         leak_i,
  input  logic                     sw_ack_i,
  input  logic                     irq_clr_i,
  output logic                     irq_o,
  output logic [DIV_W-1:0]         clk_div_o,
  output logic                     sprint_active_o
);
  localparam int unsigned SUM_W = E_W + $clog2(NUM_CORES + 1);

  sprint_st_e       state_q;
  logic             tick, start_ok, in_sprint;
  logic [SUM_W-1:0] e_sum;
  logic [DIV_W-1:0] n_active;
  logic [ACC_W-1:0] acc, warn_thr;
  logic             warn_hit, warn_hit_q, over_hit, throttle_q, irq_q;

  assign in_sprint = (state_q == ST_SPRINT);
  assign warn_thr  = (budget_i > margin_i) ? (budget_i - margin_i) : '0;
  assign start_ok  = !in_sprint && sprint_start_i && (acc <= warn_thr);
  assign warn_hit  = in_sprint && (acc >= warn_thr);
  assign over_hit  = in_sprint && (acc >= budget_i);

  sbm_sample_timer #(.PERIOD(SAMPLE_PERIOD)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start_ok),
    .tick_o    (tick)
  );

  sbm_energy_sum #(
    .NUM_CORES (NUM_CORES),
    .E_W       (E_W),
    .SUM_W     (SUM_W),
    .DIV_W     (DIV_W)
  ) u_sum (
    .energy_i (core_energy_i),
    .active_i (core_active_i),
    .sum_o    (e_sum),
    .count_o  (n_active)
  );

  sbm_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .add_en_i (in_sprint),
    .add_i    (e_sum),
    .leak_i   (leak_i),
    .acc_o    (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      warn_hit_q <= 1'b0;
      throttle_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (start_ok) state_q <= ST_SPRINT;
        ST_SPRINT: if (sw_ack_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase

      warn_hit_q <= warn_hit && !(in_sprint && sw_ack_i);

      if (!in_sprint || sw_ack_i) throttle_q <= 1'b0;
      else if (over_hit)          throttle_q <= 1'b1;

      // a fresh crossing wins over a clear in the same cycle
      if (warn_hit && !warn_hit_q) irq_q <= 1'b1;
      else if (irq_clr_i)          irq_q <= 1'b0;
    end
  end

  assign irq_o           = irq_q;
  assign sprint_active_o = in_sprint;
  assign clk_div_o       = (throttle_q && n_active != '0) ? n_active : DIV_W'(1);

  AST_IDLE_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sprint_active_o |-> clk_div_o == DIV_W'(1)); // R9
  AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sprint_active_o && sw_ack_i) |=> !sprint_active_o); // R9
  AST_REFUSE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sprint_active_o && sprint_start_i && acc > warn_thr) |=> !sprint_active_o); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o); // R6
  AST_THROTTLE_AT_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_hit && !sw_ack_i && n_active > DIV_W'(1) && $stable(core_active_i))
      |=> clk_div_o == n_active); // R8
endmodule

// File: tb/sprint_budget_mon_tb.sv
module sprint_budget_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int EW  = 8;
  localparam int AW  = 12;
  localparam int SP  = 8;
  localparam int DW  = $clog2(NC + 1);
  localparam int VW  = NC*EW + NC + AW + AW;
  localparam int NV  = 5;

  // {energy e3..e0, active mask, leak, expected total after one sample}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd40, 8'd30, 8'd20, 8'd10, 4'b1111, 12'd0,   12'd100},
    {8'd40, 8'd30, 8'd20, 8'd10, 4'b0011, 12'd0,   12'd37},
    {8'd255,8'd255,8'd255,8'd255,4'b1010, 12'd60,  12'd500},
    {8'd99, 8'd0,  8'd19, 8'd9,  4'b1100, 12'd5,   12'd95},
    {8'd100,8'd100,8'd100,8'd100,4'b0110, 12'd150, 12'd70}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sprint_start_i = 1'b0;
  logic [NC*EW-1:0]  core_energy_i = '0;
  logic [NC-1:0]     core_active_i = '0;
  logic [AW-1:0]     budget_i = '0, margin_i = '0, leak_i = '0;
  logic              sw_ack_i = 1'b0, irq_clr_i = 1'b0;
  logic              irq_o, sprint_active_o;
  logic [DW-1:0]     clk_div_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sprint_budget_mon #(
    .NUM_CORES(NC), .E_W(EW), .ACC_W(AW), .SAMPLE_PERIOD(SP)
  ) u_dut (
    .clk_i, .rst_ni, .sprint_start_i, .core_energy_i, .core_active_i,
    .budget_i, .margin_i, .leak_i, .sw_ack_i, .irq_clr_i,
    .irq_o, .clk_div_o, .sprint_active_o
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sprint_start_i = 1'b0; sw_ack_i = 1'b0; irq_clr_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic start_pulse();
    sprint_start_i = 1'b1;
    step(1);
    sprint_start_i = 1'b0;
  endtask

  function automatic int exp_div(input logic [NC-1:0] m);
    int c = 0;
    for (int i = 0; i < NC; i++) c += m[i];
    return (c == 0) ? 1 : c;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 irq", irq_o, 0);
    check("R1 div", clk_div_o, 1);
    check("R1 active", sprint_active_o, 0);

    // R2: vector table, total probed by placing budget on / above prediction
    for (int v = 0; v < NV; v++) begin
      for (int off = 0; off < 2; off++) begin
        do_reset();
        core_energy_i = VEC[v][VW-1 -: NC*EW];
        core_active_i = VEC[v][2*AW +: NC];
        leak_i        = VEC[v][AW +: AW];
        budget_i      = VEC[v][0 +: AW] + AW'(off);
        margin_i      = '0;
        start_pulse();
        step(SP + 1);
        check($sformatf("R2 vec%0d off%0d", v, off), clk_div_o,
              off == 0 ? exp_div(core_active_i) : 1);
      end
    end

    // R5: first sample SP edges after start, throttle one edge later
    do_reset();
    core_energy_i = {8'd0, 8'd0, 8'd5, 8'd5}; core_active_i = 4'b0011;
    leak_i = '0; budget_i = 12'd10; margin_i = '0;
    start_pulse();
    step(SP - 1);
    check("R5 before sample", clk_div_o, 1);
    step(1);
    check("R5 sample edge", clk_div_o, 1);
    step(1);
    check("R5 after sample", clk_div_o, 2);

    // R3: leak larger than gathered energy clamps total at 0
    do_reset();
    core_energy_i = {8'd1, 8'd1, 8'd1, 8'd1}; core_active_i = 4'b1111;
    leak_i = 12'd100; budget_i = 12'd1; margin_i = '0;
    start_pulse();
    step(SP + 1);
    check("R3 clamp zero", clk_div_o, 1);
    leak_i = '0; core_energy_i = {8'd10, 8'd10, 8'd10, 8'd10};
    step(SP);
    check("R3 count from zero", clk_div_o, 4);

    // R4: saturation at 4095 (wrap would fall below the budget)
    do_reset();
    core_energy_i = {4{8'd255}}; core_active_i = 4'b1111;
    leak_i = '0; budget_i = 12'd4095; margin_i = '0;
    start_pulse();
    step(4*SP + 1);
    check("R4 below full", clk_div_o, 1);
    step(SP);
    check("R4 saturated", clk_div_o, 4);

    // R6/R7/R8/R9/R10 sequence
    do_reset();
    core_energy_i = {8'd0, 8'd0, 8'd0, 8'd30}; core_active_i = 4'b0011;
    leak_i = '0; budget_i = 12'd100; margin_i = 12'd40;
    start_pulse();
    check("R10 accepted cold", sprint_active_o, 1);
    step(2*SP);
    check("R6 not yet", irq_o, 0);
    step(1);
    check("R6 raised", irq_o, 1);
    step(1);
    check("R6 held", irq_o, 1);
    irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
    check("R7 cleared", irq_o, 0);
    step(SP);
    check("R7 no re-raise", irq_o, 0);
    check("R8 under budget", clk_div_o, 1);
    step(SP);
    check("R8 throttle two", clk_div_o, 2);
    core_active_i = 4'b0111; step(1);
    check("R8 tracks count", clk_div_o, 3);
    core_active_i = 4'b0000; step(1);
    check("R8 minimum one", clk_div_o, 1);
    core_active_i = 4'b0011;
    sw_ack_i = 1'b1; step(1); sw_ack_i = 1'b0;
    check("R9 sprint ended", sprint_active_o, 0);
    check("R9 nominal clock", clk_div_o, 1);
    start_pulse();
    check("R10 refused hot", sprint_active_o, 0);
    step(3);
    check("R10 still idle", sprint_active_o, 0);
    leak_i = 12'd4095;
    step(SP + 1);
    start_pulse();
    check("R10 accepted cooled", sprint_active_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule